// File: doc/BRIEF.md
# Equivalent-Time Ripple Sample Sequencer

This block schedules analog-to-digital conversions of the filtered input-ripple waveform of a multi-phase buck converter. A full estimation vector holds K samples on an evenly spaced grid across one switching period, with K at least twice the phase count. Slot 0 lies at the start of phase-0 top-switch conduction, and slot i lies floor(i·P/K) clock cycles later, where P is the period length in clock cycles. The sequencer takes only one slot per switching period. Slot i is converted in the i-th period of the acquisition, so a vector spans K periods and the converter can run at a very low rate while the waveform stays stationary.

The controller gives a period-start pulse, the period length, the slot count and an abort line that signals a transient. The sequencer issues one convert strobe per period. It waits for the converter's data/valid handshake and writes each result to an external sample buffer through a write port. Once the last slot has been written, it flags the vector as ready. It then issues no more strobes or writes until the consumer acknowledges the vector.

The sequencer is a five-state machine:
- ARM waits for a period start.
- WAIT counts toward the slot offset.
- CONV is the one-cycle convert strobe.
- DATA waits for the converter result.
- HOLD freezes the finished vector.

Its transitions are:
- start (ARM→CONV when the offset is zero, otherwise ARM→WAIT).
- hit (WAIT→CONV).
- issue (CONV→DATA).
- store (DATA→ARM).
- finish (DATA→HOLD).
- release (HOLD→ARM).
- restart (any of WAIT/CONV/DATA→ARM on abort, and WAIT→ARM on an early period start).

Offsets are tracked with two accumulators that add P and K, so no divider is needed.

Top module: `ripple_eqt_seq`

## Requirements
- R1: After reset, conv_req, buf_we, vec_ready and seq_err are low and slot_idx is 0.
- R2: Each period_start pulse accepted in ARM produces at most one conv_req. While slot i is pending, slot_idx reads i. Slots are taken in order 0 to K-1, one per accepted pulse. A period_start that arrives while the block is in DATA is ignored.
- R3: For slot i, conv_req is high for exactly one cycle. That cycle begins at the clock edge that comes floor(i·P/K) edges after the edge at which period_start is sampled high. P is period_len and K is slot_count.
- R4: Any slot_count from 2 to MAX_SLOTS gives a grid with spacing P/K. Offsets are floored, and the last slot lands at floor((K-1)·P/K).
- R5: The first adc_valid after a conv_req is stored. In the following cycle, buf_we is high for one cycle with buf_addr equal to the slot number and buf_wdata equal to adc_data. An adc_valid that arrives while no conversion is outstanding produces no write.
- R6: vec_ready is high for exactly one cycle, in the cycle after the write of slot K-1.
- R7: After vec_ready, no conv_req and no buf_we occur until consume_ack is sampled high, even if period_start pulses arrive. slot_idx then reads 0, and the next period_start starts slot 0.
- R8: An abort sampled in WAIT, CONV or DATA clears the acquisition: slot_idx becomes 0, no pending result is written, and slot 0 starts on the next period_start. abort takes priority over adc_valid in the same cycle. An abort during HOLD is ignored.
- R9: A period_start sampled in WAIT, including in the very cycle the offset would be reached, skips that slot. seq_err is high for one cycle in the following cycle, no conv_req is issued, slot_idx becomes 0, and the acquisition restarts at slot 0 on the next period_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_start | input | 1 | One-cycle pulse at the start of phase-0 conduction |
| period_len | input | PER_W | Switching period P in clock cycles |
| slot_count | input | $clog2(MAX_SLOTS+1) | Samples per vector K (2..MAX_SLOTS) |
| abort | input | 1 | Transient detected; discard the acquisition |
| adc_data | input | DATA_W | Converter result |
| adc_valid | input | 1 | Converter result valid |
| consume_ack | input | 1 | Consumer has read the finished vector |
| conv_req | output | 1 | One-cycle convert strobe |
| slot_idx | output | $clog2(MAX_SLOTS) | Slot currently being acquired |
| buf_we | output | 1 | Sample buffer write enable |
| buf_addr | output | $clog2(MAX_SLOTS) | Sample buffer write address (slot number) |
| buf_wdata | output | DATA_W | Sample buffer write data |
| vec_ready | output | 1 | One-cycle flag: vector complete |
| seq_err | output | 1 | One-cycle flag: period start arrived before the slot offset |

## Verification
Two events can collide in the same cycle, and each collision has a defined winner.

The first collision is a period start that lands exactly in the cycle in which the WAIT counter reaches the offset. The bench provokes it by placing a second pulse 10 cycles after the first while slot 1 is pending with P=40 and K=4. It expects seq_err one cycle later, no strobe, and slot_idx back at 0.

The second collision is abort sampled together with adc_valid in DATA. The bench expects no buffer write and slot_idx cleared.

Every other slot is judged by counting clock edges from the sampled pulse to the strobe and comparing the count with floor(i·P/K).

// File: rtl/ripple_eqt_pkg.sv
package ripple_eqt_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_ARM  = 3'd0,   // waiting for a period start
        ST_WAIT = 3'd1,   // counting toward the slot offset
        ST_CONV = 3'd2,   // one-cycle convert strobe
        ST_DATA = 3'd3,   // waiting for the converter result
        ST_HOLD = 3'd4    // vector complete, frozen until acknowledged
    } eqt_state_t;

endpackage

// File: rtl/eqt_offset_gen.sv
// Divider-free offset tracker.
// tgt_q holds i*P for the pending slot i.
// run_q holds c*K for the current cycle count c within the period.
// The slot fires in the cycle c at which (c+1)*K > i*P, i.e. c = floor(i*P/K).
module eqt_offset_gen #(
    parameter int PER_W = 16,
    parameter int KW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] per_len,
    input  logic [KW-1:0]    k_cnt,
    input  logic             tgt_clr,
    input  logic             tgt_adv,
    input  logic             run_first,
    input  logic             run_step,
    output logic             hit_first,
    output logic             hit_run
);
    localparam int AW  = PER_W + KW;
    localparam int AW1 = AW + 1;

    logic [AW-1:0] tgt_q;
    logic [AW-1:0] run_q;
    logic [AW-1:0] per_ext;
    logic [AW-1:0] k_ext;

    assign per_ext = AW'(per_len);
    assign k_ext   = AW'(k_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q <= '0;
            run_q <= '0;
        end else begin
            if (tgt_clr) begin
                tgt_q <= '0;
            end else if (tgt_adv) begin
                tgt_q <= tgt_q + per_ext;
            end
            if (run_first) begin
                run_q <= k_ext;
            end else if (run_step) begin
                run_q <= run_q + k_ext;
            end
        end
    end

    // Offset zero check for the pulse cycle itself (c = 0)
    assign hit_first = k_ext > tgt_q;
    // Offset check for cycles c >= 1 while counting
    assign hit_run   = (AW1'(run_q) + AW1'(k_ext)) > AW1'(tgt_q);

endmodule

// File: rtl/eqt_ctrl.sv
module eqt_ctrl
    import ripple_eqt_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int KW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_start,
    input  logic             abort,
    input  logic             adc_valid,
    input  logic             consume_ack,
    input  logic [KW-1:0]    k_cnt,
    input  logic             hit_first,
    input  logic             hit_run,
    output eqt_state_t       state_o,
    output logic [IDX_W-1:0] slot_o,
    output logic             tgt_clr,
    output logic             tgt_adv,
    output logic             run_first,
    output logic             run_step,
    output logic             capture,
    output logic             capture_last,
    output logic             early_err
);
    eqt_state_t       state_q, state_n;
    logic [IDX_W-1:0] slot_q, slot_n;
    logic             is_last;

    assign is_last = (KW'(slot_q) + KW'(1)) == k_cnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
            slot_q  <= '0;
        end else begin
            state_q <= state_n;
            slot_q  <= slot_n;
        end
    end

    // Next state and strobes
    always_comb begin
        state_n      = state_q;
        slot_n       = slot_q;
        tgt_clr      = 1'b0;
        tgt_adv      = 1'b0;
        run_first    = 1'b0;
        run_step     = 1'b0;
        capture      = 1'b0;
        capture_last = 1'b0;
        early_err    = 1'b0;
        unique case (state_q)
            ST_ARM: begin
                if (abort) begin
                    slot_n  = '0;
                    tgt_clr = 1'b1;
                end else if (period_start) begin
                    // start
                    if (hit_first) begin
                        state_n = ST_CONV;
                    end else begin
                        run_first = 1'b1;
                        state_n   = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (abort || period_start) begin
                    // restart; an early period start also flags an error
                    early_err = !abort;
                    slot_n    = '0;
                    tgt_clr   = 1'b1;
                    state_n   = ST_ARM;
                end else if (hit_run) begin
                    // hit
                    state_n = ST_CONV;
                end else begin
                    run_step = 1'b1;
                end
            end
            ST_CONV: begin
                if (abort) begin
                    slot_n  = '0;
                    tgt_clr = 1'b1;
                    state_n = ST_ARM;
                end else begin
                    // issue
                    state_n = ST_DATA;
                end
            end
            ST_DATA: begin
                if (abort) begin
                    slot_n  = '0;
                    tgt_clr = 1'b1;
                    state_n = ST_ARM;
                end else if (adc_valid) begin
                    capture = 1'b1;
                    if (is_last) begin
                        // finish
                        capture_last = 1'b1;
                        state_n      = ST_HOLD;
                    end else begin
                        // store
                        slot_n  = slot_q + 1'b1;
                        tgt_adv = 1'b1;
                        state_n = ST_ARM;
                    end
                end
            end
            ST_HOLD: begin
                if (consume_ack) begin
                    // release
                    slot_n  = '0;
                    tgt_clr = 1'b1;
                    state_n = ST_ARM;
                end
            end
            default: begin
                state_n = ST_ARM;
            end
        endcase
    end

    assign state_o = state_q;
    assign slot_o  = slot_q;

endmodule

// File: rtl/eqt_capture.sv
// Registered outputs: buffer write port, completion flag, error flag.
module eqt_capture #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              capture_last,
    input  logic              early_err,
    input  logic [IDX_W-1:0]  slot,
    input  logic [DATA_W-1:0] adc_data,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_addr,
    output logic [DATA_W-1:0] buf_wdata,
    output logic              vec_ready,
    output logic              seq_err
);
    logic last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_we    <= 1'b0;
            buf_addr  <= '0;
            buf_wdata <= '0;
            last_q    <= 1'b0;
            vec_ready <= 1'b0;
            seq_err   <= 1'b0;
        end else begin
            buf_we    <= capture;
            last_q    <= capture_last;
            vec_ready <= last_q;
            seq_err   <= early_err;
            if (capture) begin
                buf_addr  <= slot;
                buf_wdata <= adc_data;
            end
        end
    end

endmodule

// File: rtl/ripple_eqt_seq.sv
module ripple_eqt_seq
    import ripple_eqt_pkg::*;
#(
    parameter int PER_W     = 16,
    parameter int MAX_SLOTS = 16,
    parameter int DATA_W    = 12,
    localparam int IDX_W    = $clog2(MAX_SLOTS),
    localparam int KW       = $clog2(MAX_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_start,
    input  logic [PER_W-1:0]  period_len,
    input  logic [KW-1:0]     slot_count,
    input  logic              abort,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              adc_valid,
    input  logic              consume_ack,
    output logic              conv_req,
    output logic [IDX_W-1:0]  slot_idx,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_addr,
    output logic [DATA_W-1:0] buf_wdata,
    output logic              vec_ready,
    output logic              seq_err
);
    eqt_state_t state;
    logic       tgt_clr, tgt_adv, run_first, run_step;
    logic       hit_first, hit_run;
    logic       capture, capture_last, early_err;

    eqt_offset_gen #(
        .PER_W (PER_W),
        .KW    (KW)
    ) offset_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_len   (period_len),
        .k_cnt     (slot_count),
        .tgt_clr   (tgt_clr),
        .tgt_adv   (tgt_adv),
        .run_first (run_first),
        .run_step  (run_step),
        .hit_first (hit_first),
        .hit_run   (hit_run)
    );

    eqt_ctrl #(
        .IDX_W (IDX_W),
        .KW    (KW)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .abort        (abort),
        .adc_valid    (adc_valid),
        .consume_ack  (consume_ack),
        .k_cnt        (slot_count),
        .hit_first    (hit_first),
        .hit_run      (hit_run),
        .state_o      (state),
        .slot_o       (slot_idx),
        .tgt_clr      (tgt_clr),
        .tgt_adv      (tgt_adv),
        .run_first    (run_first),
        .run_step     (run_step),
        .capture      (capture),
        .capture_last (capture_last),
        .early_err    (early_err)
    );

    eqt_capture #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) cap_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (capture),
        .capture_last (capture_last),
        .early_err    (early_err),
        .slot         (slot_idx),
        .adc_data     (adc_data),
        .buf_we       (buf_we),
        .buf_addr     (buf_addr),
        .buf_wdata    (buf_wdata),
        .vec_ready    (vec_ready),
        .seq_err      (seq_err)
    );

    assign conv_req = (state == ST_CONV);

endmodule

// File: rtl/ripple_eqt_seq_chk.sv
module ripple_eqt_seq_chk #(
    parameter int IDX_W  = 4,
    parameter int KW     = 5,
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              period_start,
    input logic [KW-1:0]     slot_count,
    input logic              abort,
    input logic              adc_valid,
    input logic              consume_ack,
    input logic              conv_req,
    input logic [IDX_W-1:0]  slot_idx,
    input logic              buf_we,
    input logic [IDX_W-1:0]  buf_addr,
    input logic              vec_ready,
    input logic              seq_err
);
    // Frozen window observed at the ports: from vec_ready until consume_ack
    logic frozen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frozen <= 1'b0;
        end else if (consume_ack) begin
            frozen <= 1'b0;
        end else if (vec_ready) begin
            frozen <= 1'b1;
        end
    end

    a_r1_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        KW'(slot_idx) < slot_count);

    a_r3_conv_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    a_r5_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> $past(adc_valid));

    a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (KW'(buf_addr) < slot_count));

    a_r6_ready_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        vec_ready |-> $past(buf_we));

    a_r6_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        vec_ready |=> !vec_ready);

    a_r7_frozen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> (!conv_req && !buf_we));

    a_r8_abort_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !conv_req);

    a_r9_err_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> $past(period_start));

    a_r9_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> !conv_req);

endmodule

bind ripple_eqt_seq ripple_eqt_seq_chk #(
    .IDX_W  (IDX_W),
    .KW     (KW),
    .DATA_W (DATA_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .slot_count   (slot_count),
    .abort        (abort),
    .adc_valid    (adc_valid),
    .consume_ack  (consume_ack),
    .conv_req     (conv_req),
    .slot_idx     (slot_idx),
    .buf_we       (buf_we),
    .buf_addr     (buf_addr),
    .vec_ready    (vec_ready),
    .seq_err      (seq_err)
);

// File: tb/ripple_eqt_seq_tb_top.sv
`timescale 1ns/1ps
module ripple_eqt_seq_tb_top;
    localparam int PER_W = 16, MAX_SLOTS = 16, DATA_W = 12;
    localparam int IDX_W = $clog2(MAX_SLOTS), KW = $clog2(MAX_SLOTS + 1);

    // Stimulus/expected table: period P, slot count K, expected last-slot offset
    localparam int NV = 5;
    localparam int VEC_P   [NV] = '{20, 37, 100, 9, 64};
    localparam int VEC_K   [NV] = '{4, 6, 16, 2, 8};
    localparam int VEC_OFF [NV] = '{15, 30, 93, 4, 56};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              period_start = 1'b0;
    logic [PER_W-1:0]  period_len = 16'd40;
    logic [KW-1:0]     slot_count = 5'd4;
    logic              abort = 1'b0;
    logic [DATA_W-1:0] adc_data = '0;
    logic              adc_valid = 1'b0;
    logic              consume_ack = 1'b0;
    logic              conv_req;
    logic [IDX_W-1:0]  slot_idx;
    logic              buf_we;
    logic [IDX_W-1:0]  buf_addr;
    logic [DATA_W-1:0] buf_wdata;
    logic              vec_ready;
    logic              seq_err;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    ripple_eqt_seq #(
        .PER_W(PER_W), .MAX_SLOTS(MAX_SLOTS), .DATA_W(DATA_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .period_start(period_start),
        .period_len(period_len), .slot_count(slot_count), .abort(abort),
        .adc_data(adc_data), .adc_valid(adc_valid), .consume_ack(consume_ack),
        .conv_req(conv_req), .slot_idx(slot_idx), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .vec_ready(vec_ready),
        .seq_err(seq_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a one-cycle period start; returns at the first negedge after it is sampled
    task automatic pulse_start();
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
    endtask

    task automatic wait_conv(output int j);
        j = 1;
        while (!conv_req && j < 3000) begin
            @(negedge clk);
            j++;
        end
    endtask

    // Count strobes and writes over n cycles
    task automatic watch_quiet(input int n, input string req);
        int hits = 0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (conv_req || buf_we) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    task automatic do_slot(input int i, input int p, input int k, input int data);
        int j;
        int exp_j;
        pulse_start();
        wait_conv(j);
        exp_j = (i * p) / k + 1;
        chk(j == exp_j, "R3 offset", j, exp_j);
        chk(slot_idx == IDX_W'(i), "R2 slot index", int'(slot_idx), i);
        @(negedge clk);
        chk(!conv_req, "R3 single strobe", int'(conv_req), 0);
        adc_data  = DATA_W'(data);
        adc_valid = 1'b1;
        @(negedge clk);
        adc_valid = 1'b0;
        chk(buf_we && buf_addr == IDX_W'(i) && buf_wdata == DATA_W'(data),
            "R5 write", int'(buf_wdata), data);
    endtask

    task automatic full_vector(input int p, input int k, input int seed, input bit ack);
        period_len = PER_W'(p);
        slot_count = KW'(k);
        for (int i = 0; i < k; i++) do_slot(i, p, k, seed + 7 * i);
        chk(!vec_ready, "R6 not early", int'(vec_ready), 0);
        @(negedge clk);
        chk(vec_ready, "R6 ready", int'(vec_ready), 1);
        @(negedge clk);
        chk(!vec_ready, "R6 one cycle", int'(vec_ready), 0);
        if (ack) begin
            consume_ack = 1'b1;
            @(negedge clk);
            consume_ack = 1'b0;
            chk(slot_idx == '0, "R7 release", int'(slot_idx), 0);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int j;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!conv_req && !buf_we && !vec_ready && !seq_err, "R1 outputs", 
            int'({conv_req, buf_we, vec_ready, seq_err}), 0);
        chk(slot_idx == '0, "R1 slot", int'(slot_idx), 0);

        // R5: stray valid with no conversion outstanding
        adc_valid = 1'b1;
        @(negedge clk);
        adc_valid = 1'b0;
        @(negedge clk);
        chk(!buf_we, "R5 stray valid ignored", int'(buf_we), 0);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            chk(((VEC_K[v] - 1) * VEC_P[v]) / VEC_K[v] == VEC_OFF[v], "R4 table",
                ((VEC_K[v] - 1) * VEC_P[v]) / VEC_K[v], VEC_OFF[v]);
            full_vector(VEC_P[v], VEC_K[v], 100 * v + 3, 1'b1);
        end

        // R7 freeze (and R8 abort ignored in HOLD)
        full_vector(40, 4, 500, 1'b0);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        pulse_start();
        watch_quiet(50, "R7 frozen");
        chk(slot_idx == IDX_W'(3), "R8 abort ignored in hold", int'(slot_idx), 3);
        consume_ack = 1'b1;
        @(negedge clk);
        consume_ack = 1'b0;
        full_vector(40, 4, 600, 1'b1);

        // R8 abort colliding with adc_valid in DATA
        do_slot(0, 40, 4, 11);
        pulse_start();
        wait_conv(j);
        chk(j == 11, "R8 setup offset", j, 11);
        @(negedge clk);
        adc_valid = 1'b1;
        abort     = 1'b1;
        @(negedge clk);
        adc_valid = 1'b0;
        abort     = 1'b0;
        chk(!buf_we, "R8 no write on abort", int'(buf_we), 0);
        chk(slot_idx == '0, "R8 slot cleared", int'(slot_idx), 0);
        watch_quiet(20, "R8 quiet after abort");
        full_vector(40, 4, 700, 1'b1);

        // R9 early period start landing on the offset cycle of slot 1
        do_slot(0, 40, 4, 21);
        pulse_start();
        repeat (9) @(negedge clk);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        chk(seq_err, "R9 error flag", int'(seq_err), 1);
        chk(!conv_req, "R9 slot skipped", int'(conv_req), 0);
        chk(slot_idx == '0, "R9 restart slot", int'(slot_idx), 0);
        @(negedge clk);
        chk(!seq_err, "R9 error one cycle", int'(seq_err), 0);
        watch_quiet(20, "R9 quiet after error");
        full_vector(40, 4, 800, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule